// File: doc/BRIEF.md
# Deterministic-Latency Comma Word Aligner

This block sits between a deserializer and an 8b/10b decoder. It takes 10-bit parallel words whose boundary is arbitrary with respect to the encoded symbols. It moves the boundary until a K28.5 comma appears at the current boundary. The boundary only ever moves one serial bit at a time, under a small state machine, so the resulting offset is always one of ten known values. That offset is reported so that link layers can account for the receive delay it adds.

A search is launched from the alignment request input. In automatic mode only a rising edge of the request counts. In manual mode a request held high also keeps the search stepping. After each one-bit step the machine lets the shifted data settle for a fixed number of cycles. It then watches a fixed number of words at that boundary before stepping again. When a comma is seen, the machine locks. From then on it presents every word on the comma-defined boundary until it is reset or asked to align again.

Top module: `cwa_word_aligner`

## Requirements
- R1: While the synchronous active-high reset is high, and in the first cycle after it, sync_locked, comma_hit and slip_count are all 0 and no search is running.
- R2: Serial order is bit 0 first. The comma is 10'h17C (negative disparity) or 10'h283 (positive disparity). comma_hit is high for exactly the cycles whose aligned_word equals one of those two codes.
- R3: aligned_word is registered. After the edge that takes word n, it holds the 10 stream bits that start slip_count bits into word n-1, i.e. bits [slip_count +: 10] of {word n, word n-1}.
- R4: slip_count stays in 0..9. Apart from a restart to 0, each change raises it by exactly 1, and 9 is followed by 0.
- R5: After slip_count changes, it holds for at least the settle interval (2 cycles) before it can step again, unless a restart occurs.
- R6: When no comma is present, consecutive steps are exactly SETTLE_CYC + DWELL_WORDS (2 + 16 = 18) cycles apart.
- R7: When a comma appears at the current boundary during the watch window, sync_locked rises in the same cycle as comma_hit. slip_count then equals the bit offset of the comma relative to the deserializer word boundary.
- R8: Once locked, sync_locked and slip_count hold whatever data arrives, including a stream whose phase has moved, until reset or a new rising edge of align_req.
- R9: In automatic mode (manual_mode = 0) only a rising edge of align_req starts a search. A level already high through reset, or one held high after lock, starts nothing.
- R10: In manual mode, align_req high while idle starts a search. Steps occur only while align_req is high, and with align_req low slip_count is frozen.
- R11: A rising edge of align_req in any state restarts the search. After that edge, sync_locked is 0 and slip_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | WORD_W | Raw word from the deserializer, bit 0 received first |
| align_req | input | 1 | Alignment request (edge or level, per mode) |
| manual_mode | input | 1 | 1 = level-sensitive manual mode, 0 = automatic edge mode |
| aligned_word | output | WORD_W | Word on the current boundary, registered |
| comma_hit | output | 1 | High when aligned_word is a comma |
| sync_locked | output | 1 | Boundary locked on a comma |
| slip_count | output | $clog2(WORD_W) | Bit offset of the current boundary |

## Verification
The properties assume that align_req and manual_mode change only between clock edges and that manual_mode is constant while a search is running. They also assume that a comma can appear in the stream at only one bit phase. The bench meets the last condition by building its stream from commas and alternating-bit filler words only. In that stream, runs of five equal bits occur only inside a comma, so no false comma can form at any other offset. Comma spacing is drawn below the watch window so that every search can finish. Phase changes are applied only while the block is locked or just before a restart.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_HUNT,
    ST_LOCK
  } cwa_state_e;

  // comma codes, bit 0 is the first serial bit
  localparam logic [9:0] COMMA_NEG = 10'h17C;
  localparam logic [9:0] COMMA_POS = 10'h283;

endpackage

// File: rtl/cwa_window.sv
module cwa_window #(
  parameter int W     = 10,
  parameter int OFS_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     din,
  input  logic [OFS_W-1:0] ofs,
  output logic [W-1:0]     win
);

  localparam int PAIR_W = 2 * W;

  logic [W-1:0]      prev_q;
  logic [PAIR_W-1:0] pair;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= din;
  end

  assign pair = {din, prev_q};

  // one-bit step per offset value; older word occupies the low half
  always_comb begin
    win = pair[W-1:0];
    for (int k = 0; k < W; k++) begin
      if (ofs == OFS_W'(k)) win = pair[k +: W];
    end
  end

endmodule

// File: rtl/cwa_comma_match.sv
module cwa_comma_match
  import cwa_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0] win,
  output logic         hit
);

  localparam int NPAT = 2;
  localparam logic [NPAT-1:0][W-1:0] PATS = {W'(COMMA_POS), W'(COMMA_NEG)};

  logic [NPAT-1:0] eq;

  for (genvar i = 0; i < NPAT; i++) begin : g_pat
    assign eq[i] = (win == PATS[i]);
  end

  assign hit = |eq;

endmodule

// File: rtl/cwa_slip_fsm.sv
module cwa_slip_fsm
  import cwa_pkg::*;
#(
  parameter int W      = 10,
  parameter int SETTLE = 2,
  parameter int DWELL  = 16,
  parameter int OFS_W  = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             manual,
  input  logic             hit,
  output logic [OFS_W-1:0] ofs,
  output logic             locked
);

  localparam int SET_W = $clog2(SETTLE + 1);
  localparam int DW_W  = $clog2(DWELL + 1);
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(W - 1);

  cwa_state_e        state;
  logic              req_q;
  logic              rise;
  logic              start;
  logic              slip_ok;
  logic [OFS_W-1:0]  ofs_q;
  logic [OFS_W-1:0]  ofs_nxt;
  logic              lock_q;
  logic [SET_W-1:0]  settle_q;
  logic [DW_W-1:0]   dwell_q;

  // history tracks the input through reset so a held level is no edge
  always_ff @(posedge clk) req_q <= req;

  assign rise    = req & ~req_q;
  assign start   = rise | (manual & req & (state == ST_IDLE));
  assign slip_ok = ~manual | req;
  assign ofs_nxt = (ofs_q == LAST_OFS) ? '0 : ofs_q + OFS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ofs_q    <= '0;
      lock_q   <= 1'b0;
      settle_q <= '0;
      dwell_q  <= '0;
    end else if (start) begin
      state    <= ST_SETTLE;
      ofs_q    <= '0;
      lock_q   <= 1'b0;
      settle_q <= SET_W'(SETTLE);
    end else begin
      case (state)
        ST_SETTLE: begin
          if (settle_q <= SET_W'(1)) begin
            state   <= ST_HUNT;
            dwell_q <= DW_W'(DWELL);
          end else begin
            settle_q <= settle_q - SET_W'(1);
          end
        end
        ST_HUNT: begin
          if (hit) begin
            state  <= ST_LOCK;
            lock_q <= 1'b1;
          end else if (dwell_q <= DW_W'(1)) begin
            dwell_q <= DW_W'(DWELL);
            if (slip_ok) begin
              ofs_q    <= ofs_nxt;
              state    <= ST_SETTLE;
              settle_q <= SET_W'(SETTLE);
            end
          end else begin
            dwell_q <= dwell_q - DW_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign ofs    = ofs_q;
  assign locked = lock_q;

endmodule

// File: rtl/cwa_word_aligner.sv
module cwa_word_aligner #(
  parameter int WORD_W      = 10,
  parameter int SETTLE_CYC  = 2,
  parameter int DWELL_WORDS = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [WORD_W-1:0]         rx_word,
  input  logic                      align_req,
  input  logic                      manual_mode,
  output logic [WORD_W-1:0]         aligned_word,
  output logic                      comma_hit,
  output logic                      sync_locked,
  output logic [$clog2(WORD_W)-1:0] slip_count
);

  localparam int OFS_W = $clog2(WORD_W);

  logic [WORD_W-1:0] win;
  logic              hit;
  logic [OFS_W-1:0]  ofs;
  logic              locked;
  logic [WORD_W-1:0] word_q;
  logic              hit_q;

  cwa_window #(.W(WORD_W), .OFS_W(OFS_W)) u_win (
    .clk (clk),
    .rst (rst),
    .din (rx_word),
    .ofs (ofs),
    .win (win)
  );

  cwa_comma_match #(.W(WORD_W)) u_match (
    .win (win),
    .hit (hit)
  );

  cwa_slip_fsm #(
    .W      (WORD_W),
    .SETTLE (SETTLE_CYC),
    .DWELL  (DWELL_WORDS),
    .OFS_W  (OFS_W)
  ) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .req    (align_req),
    .manual (manual_mode),
    .hit    (hit),
    .ofs    (ofs),
    .locked (locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      word_q <= win;
      hit_q  <= hit;
    end
  end

  assign aligned_word = word_q;
  assign comma_hit    = hit_q;
  assign sync_locked  = locked;
  assign slip_count   = ofs;

endmodule

// File: rtl/cwa_word_aligner_chk.sv
module cwa_word_aligner_chk #(
  parameter int WORD_W = 10
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      align_req,
  input logic                      manual_mode,
  input logic [WORD_W-1:0]         aligned_word,
  input logic                      comma_hit,
  input logic                      sync_locked,
  input logic [$clog2(WORD_W)-1:0] slip_count
);

  localparam int OW = $clog2(WORD_W);
  localparam logic [OW-1:0] TOP_OFS = OW'(WORD_W - 1);

  logic req_d;
  logic restart;

  always_ff @(posedge clk) req_d <= align_req;
  assign restart = align_req & ~req_d;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!sync_locked && !comma_hit && slip_count == '0));

  // R4
  slip_range_chk: assert property (@(posedge clk) disable iff (rst)
    slip_count <= TOP_OFS);

  // R4
  slip_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(slip_count) |->
      (slip_count == '0 || slip_count == OW'($past(slip_count) + OW'(1))));

  // R5
  settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(slip_count) && !restart) |=> ($stable(slip_count) || restart));

  // R7
  lock_on_comma_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_locked) |->
      (comma_hit && (aligned_word == WORD_W'(10'h17C) || aligned_word == WORD_W'(10'h283))));

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_locked && !restart) |=> (sync_locked && $stable(slip_count)));

  // R11
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!sync_locked && slip_count == '0));

endmodule

bind cwa_word_aligner cwa_word_aligner_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .align_req    (align_req),
  .manual_mode  (manual_mode),
  .aligned_word (aligned_word),
  .comma_hit    (comma_hit),
  .sync_locked  (sync_locked),
  .slip_count   (slip_count)
);

// File: tb/cwa_word_aligner_tb.sv
`timescale 1ns/1ps
module cwa_word_aligner_tb_top;

  localparam int WW     = 10;
  localparam int SETTLE = 2;
  localparam int DWELL  = 16;
  localparam int STEP   = SETTLE + DWELL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [WW-1:0] rx_word = '0;
  logic          align_req = 1'b0;
  logic          manual_mode = 1'b0;
  logic [WW-1:0] aligned_word;
  logic          comma_hit;
  logic          sync_locked;
  logic [3:0]    slip_count;

  always #2.5 clk = ~clk;

  cwa_word_aligner #(.WORD_W(WW), .SETTLE_CYC(SETTLE), .DWELL_WORDS(DWELL)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .rx_word      (rx_word),
    .align_req    (align_req),
    .manual_mode  (manual_mode),
    .aligned_word (aligned_word),
    .comma_hit    (comma_hit),
    .sync_locked  (sync_locked),
    .slip_count   (slip_count)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_comma(logic [WW-1:0] w);
    return (w == 10'h17C) || (w == 10'h283);
  endfunction

  // ---------------- stream generator ----------------
  bit            bitq[$];
  bit            last_bit = 1'b0;
  bit            commas_on = 1'b1;
  int            period = 4;
  int            sym_cnt = 0;
  bit            pad_req = 1'b0;
  int            pad_ph = 0;
  logic [WW-1:0] prev_w = '0;
  logic [WW-1:0] cur_w = '0;

  task automatic push_sym(logic [WW-1:0] s);
    for (int b = 0; b < WW; b++) bitq.push_back(s[b]);
    last_bit = s[WW-1];
  endtask

  always @(negedge clk) begin
    logic [WW-1:0] w;
    if (pad_req) begin
      int pad;
      pad = (pad_ph - (bitq.size() % WW) + WW) % WW;
      for (int i = 0; i < pad; i++) begin
        last_bit = ~last_bit;
        bitq.push_back(last_bit);
      end
      pad_req = 1'b0;
    end
    while (bitq.size() < WW) begin
      if (commas_on && (sym_cnt % period == 0))
        push_sym(($urandom % 2) ? 10'h283 : 10'h17C);
      else
        push_sym(($urandom % 2) ? 10'h2AA : 10'h155);
      sym_cnt++;
    end
    for (int b = 0; b < WW; b++) w[b] = bitq.pop_front();
    rx_word <= w;
    prev_w = cur_w;
    cur_w  = w;
  end

  // ---------------- monitor ----------------
  int  cyc = 0;
  bit  stream_chk = 1'b0;
  int  exp_ph = 0;
  bit  iv_arm = 1'b0;
  bit  iv_on = 1'b0;
  int  last_cyc = 0;
  int  last_val = 0;
  bit  saw_wrap = 1'b0;
  bit  saw_lock = 1'b0;

  always @(posedge clk) begin
    #2;
    cyc++;
    if (stream_chk) begin
      logic [2*WW-1:0] pr;
      logic [WW-1:0]   ew;
      pr = {cur_w, prev_w} >> exp_ph;
      ew = pr[WW-1:0];
      check(aligned_word == ew, "R3", aligned_word, ew);       // R3
      check(comma_hit == is_comma(ew), "R2", comma_hit, is_comma(ew)); // R2
    end
    if (iv_arm) begin
      iv_arm = 1'b0;
      iv_on = 1'b1;
      last_cyc = cyc;
      last_val = slip_count;
    end else if (iv_on) begin
      if (sync_locked) saw_lock = 1'b1;
      if (int'(slip_count) != last_val) begin
        // R5 and R6: exact spacing between steps
        check(cyc - last_cyc == STEP, "R6", cyc - last_cyc, STEP);
        check(int'(slip_count) == (last_val + 1) % WW, "R4", slip_count, (last_val + 1) % WW);
        if (last_val == WW - 1 && slip_count == 0) saw_wrap = 1'b1;
        last_cyc = cyc;
        last_val = slip_count;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_phase(int ph);
    pad_ph = ph;
    pad_req = 1'b1;
    ticks(4);
  endtask

  task automatic do_reset(bit lvl);
    rst = 1'b1;
    align_req = lvl;
    ticks(4);
    check(!sync_locked && !comma_hit && slip_count == 0, "R1",
          {sync_locked, comma_hit, slip_count}, 0);
    rst = 1'b0;
    tick();
    check(!sync_locked && slip_count == 0, "R1", {sync_locked, slip_count}, 0);
  endtask

  task automatic wait_lock(int lim, output bit got);
    got = 1'b0;
    for (int i = 0; i < lim && !got; i++) begin
      tick();
      if (sync_locked) got = 1'b1;
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    bit got;
    void'($urandom(32'd4711));
    manual_mode = 1'b0;
    commas_on = 1'b1;
    period = 4;
    set_phase(0);

    // R9: level high through reset in automatic mode starts nothing
    do_reset(1'b1);
    ticks(60);
    check(!sync_locked && slip_count == 0, "R9", {sync_locked, slip_count}, 0);
    align_req = 1'b0;
    tick();

    // automatic mode, directed offsets then random ones
    for (int it = 0; it < 7; it++) begin
      int ph;
      int keep;
      ph = (it == 0) ? 9 : (it == 1) ? 0 : int'($urandom % WW);
      period = 3 + int'($urandom % 6);
      if (it > 0) begin
        // R8: phase move while locked changes nothing
        keep = slip_count;
        set_phase(ph);
        ticks(30);
        check(sync_locked == 1'b1, "R8", sync_locked, 1);
        check(int'(slip_count) == keep, "R8", slip_count, keep);
      end else begin
        set_phase(ph);
      end
      align_req = 1'b1;
      tick();
      // R11
      check(!sync_locked && slip_count == 0, "R11", {sync_locked, slip_count}, 0);
      wait_lock(400, got);
      check(got, "R7", got, 1);
      check(int'(slip_count) == ph, "R7", slip_count, ph);
      exp_ph = ph;
      stream_chk = 1'b1;
      ticks(30);
      stream_chk = 1'b0;
      // R9: request still high after lock, no restart
      check(sync_locked && int'(slip_count) == ph, "R9", slip_count, ph);
      align_req = 1'b0;
      ticks(2);
    end

    // R4, R6: no comma, full walk with wrap
    commas_on = 1'b0;
    ticks(4);
    align_req = 1'b1;
    tick();
    check(!sync_locked && slip_count == 0, "R11", {sync_locked, slip_count}, 0);
    align_req = 1'b0;
    iv_arm = 1'b1;
    ticks(STEP * 12 + 10);
    iv_on = 1'b0;
    check(saw_wrap, "R4", saw_wrap, 1);
    check(!saw_lock, "R7", saw_lock, 0);

    // R10: manual mode
    manual_mode = 1'b1;
    commas_on = 1'b1;
    period = 5;
    set_phase(6);
    do_reset(1'b1);
    ticks(3);
    align_req = 1'b0;
    ticks(100);
    check(slip_count == 0 && !sync_locked, "R10", {sync_locked, slip_count}, 0);
    align_req = 1'b1;
    ticks(STEP * 3);
    check(slip_count != 0, "R10", slip_count, 1);
    wait_lock(400, got);
    check(got, "R10", got, 1);
    check(slip_count == 6, "R10", slip_count, 6);
    ticks(40);
    check(sync_locked && slip_count == 6, "R10", slip_count, 6);
    align_req = 1'b0;
    ticks(3);

    // R10: manual search stopped part way keeps its count
    set_phase(8);
    align_req = 1'b1;
    ticks(STEP * 2 + 2);
    align_req = 1'b0;
    tick();
    begin
      int held;
      held = slip_count;
      ticks(80);
      check(int'(slip_count) == held && !sync_locked, "R10", slip_count, held);
    end

    // R1: reset while running
    do_reset(1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule